// File: doc/BRIEF.md
# Sliding-Window Parallel Insertion Sorter

This block holds the most recent N unsigned samples of width W and always presents them in ascending order. The smallest value sits in entry 0 and the largest in entry N-1. Whenever the valid strobe is high on a clock edge, the sample on the data bus joins the set and the oldest stored sample leaves it. The updated, still sorted set is visible on the output bus after that edge. The window therefore acts as a FIFO in time while staying sorted in value.

Each stored entry carries a one-hot age tag. The tag picks which entry to evict. A bank of comparators works in parallel: entry i compares itself against the incoming sample (entry >= sample). This yields a thermometer vector, and its edge marks where the new sample belongs. The entries between the eviction point and the insertion slot slide by one place toward the freed slot, and their tags slide with them. The whole update takes one clock cycle and needs no iterative loop.

A typical use is a running median or rank filter. Downstream logic picks fixed fields out of the packed output bus.

Top module: `window_sorter`

## Requirements
- R1: After reset, every entry of the output bus is zero. The internal ages are loaded so that entry i has age i+1, which makes all ages distinct.
- R2: The output bus packs entry k into bits [k*W +: W], so entry N-1 occupies the most significant W bits.
- R3: At every clock edge after reset, entry k is less than or equal to entry k+1 for every k, with unsigned comparison.
- R4: While the valid strobe is low, the output holds its value whatever is on the data bus.
- R5: When the valid strobe is high at an edge, after that edge the output holds the previous set with its oldest sample removed and the new sample added.
- R6: After any run of valid samples, the output equals the sorted list of the last N accepted samples. Zeros left over from reset count as the oldest samples.
- R7: An accepted sample gets age 1, every surviving entry's age rises by one, and the ages of the N entries stay a permutation of 1..N.
- R8: A sample larger than every stored value is placed in entry N-1. A sample smaller than or equal to every stored value is placed in entry 0.
- R9: Duplicate values are all kept, and the order stays ascending when the new sample equals stored values.
- R10: When the evicted entry is itself the correct slot for the new sample, that slot is overwritten and every other entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High to accept in_data at this edge |
| in_data | input | W | Unsigned sample to insert |
| sorted_o | output | N*W | Sorted window, entry k at bits [k*W +: W] |

## Verification
The bench drives a four-entry window. A reference FIFO of the last four samples is re-sorted after every step, and the sorted result is compared with the output bus one cycle later.

The stimulus targets the following cases:
- Samples above every stored value. A locator that failed to clamp the slot would write outside the array or drop the value.
- Samples at or below the minimum.
- Evictions that land exactly on the insertion slot. A wrong shift direction there would duplicate or lose a neighbour.
- Runs of equal values, which expose a wrong comparison sense.
- Idle cycles with a changing data bus, which would corrupt the set if the strobe were ignored.

A mis-rotated age tag shows up as the wrong sample leaving the window.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    // Direction in which the entries between the eviction point and the
    // insertion slot move during one update.
    typedef enum logic [1:0] {
        SHIFT_NONE = 2'd0,
        SHIFT_UP   = 2'd1,
        SHIFT_DOWN = 2'd2
    } shift_dir_e;

endpackage

// File: rtl/ws_evict_pick.sv
module ws_evict_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][N-1:0] age_i,
    output logic [N-1:0]        rem_oh_o,
    output logic [IW-1:0]       rem_idx_o
);

    // The oldest entry is the one whose one-hot tag has its top bit set.
    always_comb begin
        rem_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            rem_oh_o[i] = age_i[i][N-1];
            if (age_i[i][N-1]) begin
                rem_idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ws_slot_locate.sv
module ws_slot_locate
    import sorter_pkg::*;
#(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][W-1:0] data_i,
    input  logic [W-1:0]        new_i,
    input  logic [IW-1:0]       rem_idx_i,
    output logic [N-1:0]        cmp_o,
    output logic [IW-1:0]       slot_idx_o,
    output shift_dir_e          dir_o
);

    logic [IW:0] edge_d;    // lowest index holding a 1, or N if none
    logic [IW:0] rem_ext_d;
    logic [IW:0] below_d;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cmp_o[i] = (data_i[i] >= new_i);
        end

        edge_d = (IW+1)'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (cmp_o[i]) begin
                edge_d = (IW+1)'(i);
            end
        end

        rem_ext_d = {1'b0, rem_idx_i};
        below_d   = edge_d - (IW+1)'(1);

        if (rem_ext_d >= edge_d) begin
            // Eviction at or above the edge: take the high-side slot.
            slot_idx_o = edge_d[IW-1:0];
            dir_o      = (rem_ext_d == edge_d) ? SHIFT_NONE : SHIFT_UP;
        end else begin
            // Eviction below the edge: take the low-side slot.
            slot_idx_o = below_d[IW-1:0];
            dir_o      = (rem_ext_d == below_d) ? SHIFT_NONE : SHIFT_DOWN;
        end
    end

endmodule

// File: rtl/ws_shift_net.sv
module ws_shift_net
    import sorter_pkg::*;
#(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][W-1:0] data_i,
    input  logic [N-1:0][N-1:0] age_i,
    input  logic [W-1:0]        new_i,
    input  logic [IW-1:0]       slot_idx_i,
    input  logic [IW-1:0]       rem_idx_i,
    input  shift_dir_e          dir_i,
    output logic [N-1:0][W-1:0] data_o,
    output logic [N-1:0][N-1:0] age_o
);

    localparam logic [N-1:0] AGE_ONE = N'(1);

    for (genvar g = 0; g < N; g++) begin : g_entry
        localparam int LO_SRC = (g > 0) ? g - 1 : 0;
        localparam int HI_SRC = (g < N - 1) ? g + 1 : N - 1;
        localparam logic [IW-1:0] GIDX = IW'(g);

        logic from_lo_d;
        logic from_hi_d;

        always_comb begin
            from_lo_d = (dir_i == SHIFT_UP)   && (GIDX > slot_idx_i) && (GIDX <= rem_idx_i);
            from_hi_d = (dir_i == SHIFT_DOWN) && (GIDX >= rem_idx_i) && (GIDX < slot_idx_i);

            if (GIDX == slot_idx_i) begin
                data_o[g] = new_i;
                age_o[g]  = AGE_ONE;
            end else if (from_lo_d) begin
                data_o[g] = data_i[LO_SRC];
                age_o[g]  = {age_i[LO_SRC][N-2:0], 1'b0};
            end else if (from_hi_d) begin
                data_o[g] = data_i[HI_SRC];
                age_o[g]  = {age_i[HI_SRC][N-2:0], 1'b0};
            end else begin
                data_o[g] = data_i[g];
                age_o[g]  = {age_i[g][N-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/window_sorter.sv
module window_sorter
    import sorter_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic [N*W-1:0] sorted_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0][W-1:0] data;
        logic [N-1:0][N-1:0] age;
    } win_state_t;

    win_state_t st_d, st_q;

    logic [N-1:0]        rem_oh;
    logic [IW-1:0]       rem_idx;
    logic [N-1:0]        cmp_vec;
    logic [IW-1:0]       slot_idx;
    shift_dir_e          dir;
    logic [N-1:0][W-1:0] nxt_data;
    logic [N-1:0][N-1:0] nxt_age;

    ws_evict_pick #(.N(N), .IW(IW)) u_evict (
        .age_i     (st_q.age),
        .rem_oh_o  (rem_oh),
        .rem_idx_o (rem_idx)
    );

    ws_slot_locate #(.W(W), .N(N), .IW(IW)) u_locate (
        .data_i     (st_q.data),
        .new_i      (in_data),
        .rem_idx_i  (rem_idx),
        .cmp_o      (cmp_vec),
        .slot_idx_o (slot_idx),
        .dir_o      (dir)
    );

    ws_shift_net #(.W(W), .N(N), .IW(IW)) u_shift (
        .data_i     (st_q.data),
        .age_i      (st_q.age),
        .new_i      (in_data),
        .slot_idx_i (slot_idx),
        .rem_idx_i  (rem_idx),
        .dir_i      (dir),
        .data_o     (nxt_data),
        .age_o      (nxt_age)
    );

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.data = nxt_data;
            st_d.age  = nxt_age;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '0;
            for (int i = 0; i < N; i++) begin
                st_q.age[i] <= N'(1) << i;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign sorted_o = st_q.data;

    // ---------------- assertions ----------------
    logic [N-1:0] age_union;
    always_comb begin
        age_union = '0;
        for (int i = 0; i < N; i++) begin
            age_union = age_union | st_q.age[i];
        end
    end

    for (genvar g = 0; g < N - 1; g++) begin : g_order_chk
        // R3
        sorted_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.data[g] <= st_q.data[g+1]);
    end

    for (genvar g = 0; g < N; g++) begin : g_age_chk
        // R7
        age_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(st_q.age[g]));
    end

    // R7
    age_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &age_union);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));

    // R5
    evict_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rem_oh));

    // R5
    new_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (st_q.data[$past(slot_idx)] == $past(in_data))
                     && st_q.age[$past(slot_idx)][0]);

    // R8
    top_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cmp_vec == '0)) |-> (slot_idx == IW'(N - 1)));

    // R8
    bottom_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&cmp_vec)) |-> (slot_idx == '0));

endmodule

// File: tb/window_sorter_tb.sv
module window_sorter_tb;

    localparam int W = 8;
    localparam int N = 4;

    typedef struct {
        logic [N*W-1:0] exp;
        string          tag;
    } exp_item_t;

    logic           clk;
    logic           rst_n;
    logic           in_valid;
    logic [W-1:0]   in_data;
    logic [N*W-1:0] sorted_o;

    int checks = 0;
    int errors = 0;

    int        win[$];
    exp_item_t exp_q[$];

    window_sorter #(.W(W), .N(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .sorted_o (sorted_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R2: entry k of the sorted window goes to bits [k*W +: W]
    function automatic logic [N*W-1:0] pack_sorted();
        int tmp[$];
        logic [N*W-1:0] v;
        tmp = win;
        tmp.sort();
        v = '0;
        for (int k = 0; k < N; k++) begin
            v[k*W +: W] = W'(tmp[k]);
        end
        return v;
    endfunction

    task automatic step(input logic v, input logic [W-1:0] d, input string tag);
        exp_item_t it;
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        if (v) begin
            win.push_back(int'(d));
            void'(win.pop_front());
        end
        it.exp = pack_sorted();
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: each driven cycle's result is visible after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                bit ord;
                it = exp_q.pop_front();
                check(sorted_o === it.exp, it.tag, sorted_o, it.exp);
                ord = 1'b1;
                for (int k = 0; k < N - 1; k++) begin
                    if (sorted_o[k*W +: W] > sorted_o[(k+1)*W +: W]) ord = 1'b0;
                end
                check(ord, "R3 ascending", sorted_o, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        for (int k = 0; k < N; k++) win.push_back(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: cleared window after reset
        check(sorted_o === '0, "R1 reset", sorted_o, '0);

        // R8: largest value goes to the top entry
        step(1'b1, 8'd200, "R8 largest");
        step(1'b1, 8'd0,   "R8 smallest");

        // R6 / R5: fill in ascending order
        step(1'b1, 8'd10, "R6 fill");
        step(1'b1, 8'd20, "R6 fill");
        step(1'b1, 8'd30, "R6 fill");
        step(1'b1, 8'd40, "R6 fill");

        // R10: the evicted slot is exactly the insertion slot
        step(1'b1, 8'd5,  "R10 overwrite low");
        step(1'b1, 8'd15, "R10 overwrite mid");

        // R4: strobe low, data bus toggling
        step(1'b0, 8'd255, "R4 idle");
        step(1'b0, 8'd1,   "R4 idle");
        step(1'b0, 8'd77,  "R4 idle");

        // R5 / R7: the four-entry example, oldest 89 leaves
        step(1'b1, 8'd89, "R7 setup");
        step(1'b1, 8'd6,  "R7 setup");
        step(1'b1, 8'd32, "R7 setup");
        step(1'b1, 8'd2,  "R7 setup");
        step(1'b1, 8'd16, "R5 evict oldest");
        step(1'b0, 8'd0,  "R5 hold");
        @(negedge clk);
        // R2: entry 3 in the top byte, entry 0 in the bottom byte
        check(sorted_o[3*W +: W] == 8'd32 && sorted_o[0 +: W] == 8'd2,
              "R2 packing", sorted_o, {8'd32, 8'd16, 8'd6, 8'd2});

        // R9: duplicates
        for (int k = 0; k < 5; k++) step(1'b1, 8'd7, "R9 duplicates");
        step(1'b1, 8'd7, "R9 equal insert");
        step(1'b1, 8'd3, "R9 below dups");
        step(1'b1, 8'd9, "R9 above dups");

        // R8: extremes against a full window
        step(1'b1, 8'd255, "R8 max value");
        step(1'b1, 8'd0,   "R8 min value");
        step(1'b1, 8'd0,   "R8 min repeat");

        // R6 / R3: mixed stream with idle gaps and small value range
        for (int k = 0; k < 300; k++) begin
            logic v;
            v = ($urandom_range(0, 3) != 0);
            step(v, W'($urandom_range(0, 15)), v ? "R6 stream" : "R4 stream idle");
        end

        step(1'b0, 8'd0, "R4 final");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule